// File: doc/BRIEF.md
# Multiply-Accumulate Product Stage

This block is the multiply front end of a multiply-accumulate datapath. It takes two 32-bit operands and a mode select (signed integer, unsigned integer or fractional). It forms a 64-bit product that the downstream accumulator can add without further conditioning. In the two integer modes the product must fit a 40-bit field. When it does not, the stage raises a one-cycle overflow-set pulse that feeds the sticky overflow status bit. If the overflow-mode control input is also high, the stage replaces the product with a large sentinel, so that the following accumulate is certain to overflow.

In fractional mode the signed product is scaled down by 24 bit positions. When the rounding control input is high, the bits shifted out are treated as a remainder and rounded half-to-even. A single register stage with a valid qualifier separates the inputs from the outputs.

Top module: `mac_prod_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `v_set` and `product` are all zero.
- R2: `out_valid` equals `in_valid` one clock earlier, and the result of an accepted operation appears on that same cycle. When `in_valid` is low, `product` keeps its previous value.
- R3: Mode encoding: `mode`=2'b00 is signed, 2'b01 is unsigned, and 2'b10 and 2'b11 are fractional. In signed mode, a two's-complement product in the range -2^39 to 2^39-1 is output exactly, sign-extended to 64 bits, with `v_set` low.
- R4: In signed mode with `omc` low, a product outside that range raises `v_set`. The output is then the low 40 product bits, sign-extended from bit 39.
- R5: In signed mode with `omc` high, an out-of-range product raises `v_set`. The output is 2^50 (0x0004_0000_0000_0000) when the product is non-negative, and the bitwise inverse of 2^50 (0xFFFB_FFFF_FFFF_FFFF) when it is negative.
- R6: In unsigned mode, a product below 2^40 is output unchanged with `v_set` low. Otherwise `v_set` rises, and with `omc` low the output is the low 40 bits, zero-extended.
- R7: In unsigned mode with `omc` high, an overflowing product is output as 2^50.
- R8: In fractional mode with `rnd` low, the output is the signed 64-bit product shifted arithmetically right by 24. `v_set` stays low in fractional mode whatever `omc` is.
- R9: In fractional mode with `rnd` high, the shifted value is incremented when the discarded 24 bits exceed 0x800000. When they equal 0x800000 exactly, its bit 0 is added. Otherwise it is left as is.
- R10: `v_set` is high only on a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| mode | input | 2 | 00 signed, 01 unsigned, 1x fractional |
| omc | input | 1 | Overflow-mode control: replace overflowing product by sentinel |
| rnd | input | 1 | Round fractional results half-to-even |
| out_valid | output | 1 | Product is valid |
| product | output | 64 | Accumulate-ready product |
| v_set | output | 1 | Pulse that sets the sticky overflow status bit |

## Verification
The signed patterns land on both sides of the 40-bit boundary: exactly +2^39 (overflow) and exactly -2^39 (fits). These separate a correct range test from one that is off by one or ignores the sign. Unsigned patterns just under and exactly at 2^40, each with and without `omc`, separate truncation from the sentinel. Fractional patterns use remainders just below, exactly at and just above one half, with both parities of the shifted value and a negative product. They tell round-half-to-even apart from round-half-up and from truncation. Random operands over all modes are then compared with a behavioural 64-bit model.

// File: rtl/mac_prod_pkg.sv
`timescale 1ns/1ps
package mac_prod_pkg;
  typedef enum logic [1:0] {
    MODE_SGN   = 2'b00,
    MODE_UNS   = 2'b01,
    MODE_FRC   = 2'b10,
    MODE_FRC_B = 2'b11
  } mac_mode_e;
endpackage

// File: rtl/mac_mult_core.sv
`timescale 1ns/1ps
module mac_mult_core #(
  parameter int OP_W = 32,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              as_signed,
  output logic [PROD_W-1:0] prod
);
  // One extra bit per operand lets one signed multiplier serve both signednesses.
  logic signed [OP_W:0]     ext_a, ext_b;
  logic signed [PROD_W-1:0] mul;

  always_comb begin
    ext_a = {as_signed & a[OP_W-1], a};
    ext_b = {as_signed & b[OP_W-1], b};
    mul   = ext_a * ext_b;
    prod  = mul;
  end
endmodule

// File: rtl/mac_int_limit.sv
`timescale 1ns/1ps
module mac_int_limit #(
  parameter int PROD_W   = 64,
  parameter int FIT_W    = 40,
  parameter int SENT_BIT = 50
) (
  input  logic [PROD_W-1:0] prod,
  input  logic              as_signed,
  input  logic              omc,
  output logic [PROD_W-1:0] res,
  output logic              ovf
);
  localparam int HI_W = PROD_W - FIT_W + 1;
  localparam logic [PROD_W-1:0] SENTINEL =
    {{(PROD_W-SENT_BIT-1){1'b0}}, 1'b1, {SENT_BIT{1'b0}}};

  logic [HI_W-1:0] hi_s;
  logic            ovf_s, ovf_u;

  always_comb begin
    hi_s  = prod[PROD_W-1:FIT_W-1];
    ovf_s = !((&hi_s) || !(|hi_s));
    ovf_u = |prod[PROD_W-1:FIT_W];
    ovf   = as_signed ? ovf_s : ovf_u;
    if (ovf && omc) begin
      res = (as_signed && prod[PROD_W-1]) ? ~SENTINEL : SENTINEL;
    end else if (as_signed) begin
      res = {{(PROD_W-FIT_W){prod[FIT_W-1]}}, prod[FIT_W-1:0]};
    end else begin
      res = {{(PROD_W-FIT_W){1'b0}}, prod[FIT_W-1:0]};
    end
  end
endmodule

// File: rtl/mac_frac_scale.sv
`timescale 1ns/1ps
module mac_frac_scale #(
  parameter int PROD_W = 64,
  parameter int SHIFT  = 24
) (
  input  logic [PROD_W-1:0] prod,
  input  logic              rnd,
  output logic [PROD_W-1:0] res
);
  localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};

  logic signed [PROD_W-1:0] scaled;
  logic [SHIFT-1:0]         rem;
  logic                     bump;

  always_comb begin
    scaled = $signed(prod) >>> SHIFT;
    rem    = prod[SHIFT-1:0];
    bump   = rnd && ((rem > HALF) || ((rem == HALF) && scaled[0]));
    res    = scaled + {{(PROD_W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/mac_prod_stage.sv
`timescale 1ns/1ps
module mac_prod_stage
  import mac_prod_pkg::*;
#(
  parameter int OP_W     = 32,
  parameter int FIT_W    = 40,
  parameter int FRAC_SH  = 24,
  parameter int SENT_BIT = 50,
  localparam int PROD_W  = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [1:0]        mode,
  input  logic              omc,
  input  logic              rnd,
  output logic              out_valid,
  output logic [PROD_W-1:0] product,
  output logic              v_set
);
  logic              is_frac, is_signed;
  logic [PROD_W-1:0] raw, int_res, frc_res;
  logic              int_ovf;
  logic [PROD_W-1:0] nxt_product;
  logic              nxt_vset;

  always_comb begin
    is_frac   = mode[1];
    is_signed = (mode != MODE_UNS);
  end

  mac_mult_core #(.OP_W(OP_W)) i_mult (
    .a(op_a), .b(op_b), .as_signed(is_signed), .prod(raw)
  );

  mac_int_limit #(.PROD_W(PROD_W), .FIT_W(FIT_W), .SENT_BIT(SENT_BIT)) i_lim (
    .prod(raw), .as_signed(is_signed), .omc(omc), .res(int_res), .ovf(int_ovf)
  );

  mac_frac_scale #(.PROD_W(PROD_W), .SHIFT(FRAC_SH)) i_frac (
    .prod(raw), .rnd(rnd), .res(frc_res)
  );

  // Next-state
  always_comb begin
    nxt_product = is_frac ? frc_res : int_res;
    nxt_vset    = in_valid && !is_frac && int_ovf;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      v_set     <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      v_set     <= nxt_vset;
      if (in_valid) begin
        product <= nxt_product;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product)); // R2
  AST_VSET_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    v_set |-> out_valid); // R10
  AST_FRAC_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1]) |=> !v_set); // R8
  AST_UNS_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_UNS && !omc) |=> (product[PROD_W-1:FIT_W] == '0)); // R6
  AST_SGN_OMC_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_SGN && omc && nxt_vset)
      |=> (product[PROD_W-1:FIT_W] != '0 && product[PROD_W-1:FIT_W] != '1)); // R5
endmodule

// File: tb/test_mac_prod_stage.sv
`timescale 1ns/1ps
module test_mac_prod_stage;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  mode;
    logic        omc;
    logic        rnd;
    logic [63:0] exp_p;
    logic        exp_v;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t TBL [NVEC] = '{
    '{32'd3,        32'd5,        2'b00, 1'b0, 1'b0, 64'd15,                  1'b0, 4'd3}, // R3
    '{32'hFFFFFFFE, 32'd7,        2'b00, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF2, 1'b0, 4'd3}, // R3
    '{32'hFFF00000, 32'h00080000, 2'b00, 1'b1, 1'b0, 64'hFFFF_FF80_0000_0000, 1'b0, 4'd3}, // R3 -2^39 fits
    '{32'h00100000, 32'h00080000, 2'b00, 1'b0, 1'b0, 64'hFFFF_FF80_0000_0000, 1'b1, 4'd4}, // R4 +2^39
    '{32'h00100000, 32'h00080000, 2'b00, 1'b1, 1'b0, 64'h0004_0000_0000_0000, 1'b1, 4'd5}, // R5
    '{32'hFFF00000, 32'h00100000, 2'b00, 1'b1, 1'b0, 64'hFFFB_FFFF_FFFF_FFFF, 1'b1, 4'd5}, // R5
    '{32'hFFFFFFFF, 32'h000000FF, 2'b01, 1'b0, 1'b0, 64'h0000_00FE_FFFF_FF01, 1'b0, 4'd6}, // R6
    '{32'hFFFFFFFF, 32'h00000100, 2'b01, 1'b1, 1'b0, 64'h0000_00FF_FFFF_FF00, 1'b0, 4'd6}, // R6
    '{32'h00010000, 32'h01000000, 2'b01, 1'b0, 1'b0, 64'd0,                   1'b1, 4'd6}, // R6 2^40
    '{32'h00010000, 32'h01000000, 2'b01, 1'b1, 1'b0, 64'h0004_0000_0000_0000, 1'b1, 4'd7}, // R7
    '{32'h01800000, 32'd1,        2'b10, 1'b0, 1'b0, 64'd1,                   1'b0, 4'd8}, // R8
    '{32'h40000000, 32'h40000000, 2'b11, 1'b1, 1'b0, 64'h0000_0010_0000_0000, 1'b0, 4'd8}, // R8
    '{32'hFF800000, 32'd1,        2'b10, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd8}, // R8
    '{32'h01800000, 32'd1,        2'b10, 1'b0, 1'b1, 64'd2,                   1'b0, 4'd9}, // R9 half, odd
    '{32'h00800000, 32'd1,        2'b10, 1'b0, 1'b1, 64'd0,                   1'b0, 4'd9}, // R9 half, even
    '{32'h00800001, 32'd1,        2'b10, 1'b0, 1'b1, 64'd1,                   1'b0, 4'd9}, // R9 above half
    '{32'hFF800000, 32'd1,        2'b10, 1'b0, 1'b1, 64'd0,                   1'b0, 4'd9}  // R9 negative half
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic [1:0]  mode;
  logic        omc, rnd;
  logic        out_valid, v_set;
  logic [63:0] product;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mac_prod_stage i_mac_prod_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .mode(mode), .omc(omc), .rnd(rnd), .out_valid(out_valid),
    .product(product), .v_set(v_set)
  );

  function automatic logic [64:0] ref_calc(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] md, input logic o, input logic r);
    logic signed [63:0] sa, sb, sp, q;
    logic [63:0] up, p;
    logic v;
    sa = $signed(a); sb = $signed(b); sp = sa * sb;
    up = {32'd0, a} * {32'd0, b};
    v = 1'b0;
    if (md[1]) begin
      q = sp >>> 24;
      if (r && ((sp[23:0] > 24'h800000) || (sp[23:0] == 24'h800000 && q[0]))) q = q + 64'sd1;
      p = q;
    end else if (md == 2'b00) begin
      if (sp > 64'sh7F_FFFF_FFFF || sp < -64'sh80_0000_0000) begin
        v = 1'b1;
        if (o) p = (sp < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
        else   p = {{24{sp[39]}}, sp[39:0]};
      end else p = sp;
    end else begin
      if (up >= (64'd1 << 40)) begin
        v = 1'b1;
        p = o ? (64'd1 << 50) : {24'd0, up[39:0]};
      end else p = up;
    end
    return {v, p};
  endfunction

  task automatic check(input string req, input logic [63:0] got_p, input logic got_v,
                       input logic [63:0] exp_p, input logic exp_v);
    checks++;
    if (got_p !== exp_p || got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: product=%h v_set=%b expected product=%h v_set=%b",
               req, got_p, got_v, exp_p, exp_v);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] md,
                        input logic o, input logic r);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; mode = md; omc = o; rnd = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; mode = '0; omc = 1'b0; rnd = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", product, v_set, 64'd0, 1'b0);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid=%b expected 0", out_valid); end
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_op(TBL[i].a, TBL[i].b, TBL[i].mode, TBL[i].omc, TBL[i].rnd);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), product, v_set, TBL[i].exp_p, TBL[i].exp_v);
    end

    // R2: latency and hold with idle inputs changing
    begin
      logic [63:0] held;
      run_op(32'd1000, 32'd1000, 2'b00, 1'b0, 1'b0);
      checks++;
      if (out_valid !== 1'b1) begin errors++; $display("FAIL R2 out_valid=%b expected 1", out_valid); end
      held = product;
      check("R2 accepted", product, v_set, 64'd1000000, 1'b0);
      op_a = 32'h00100000; op_b = 32'h00100000; omc = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R2 out_valid=%b expected 0", out_valid); end
      // R10: overflowing operands while idle raise no v_set
      check("R2 R10 idle hold", product, v_set, held, 1'b0);
    end

    // Random comparison against behavioural model (R3..R9 by mode)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [1:0]  md;
      logic        o, r;
      logic [64:0] e;
      a = $urandom; b = $urandom; md = 2'($urandom); o = 1'($urandom); r = 1'($urandom);
      if (i % 3 == 0) begin a = a >> ($urandom % 32); b = b >> ($urandom % 32); end
      e = ref_calc(a, b, md, o, r);
      run_op(a, b, md, o, r);
      check($sformatf("R%0d random mode=%b omc=%b rnd=%b a=%h b=%h",
                      md[1] ? (r ? 9 : 8) : (md[0] ? (o ? 7 : 6) : (o ? 5 : 4)), md, o, r, a, b),
            product, v_set, e[63:0], e[64]);
    end

    // R1: reset mid-stream clears outputs
    run_op(32'h7FFFFFFF, 32'h7FFFFFFF, 2'b00, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", product, v_set, 64'd0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule